// File: doc/BRIEF.md
# SPI Master Serial Clock Divider

This block derives the serial clock of an SPI master from the system clock. A prescaler counts system cycles. Each time the prescaler reaches its terminal count it produces a tick, and each tick advances a small period counter. The serial clock is high while the period counter is below a programmable high threshold. It is low from that threshold until the counter wraps. The prescale value and the cycle length therefore set the frequency, and the high threshold sets the duty cycle.

A bypass bit passes the system clock straight through as the serial clock. Two single-cycle strobes, registered alongside the serial clock, mark its rising and falling edges. The surrounding shift logic uses them to launch and capture data without sampling the divided clock itself. Software picks the field values for a target frequency. The block only executes them.

Top module: `spi_sclk_div`

## Requirements
- R1: The 32-bit configuration word holds five fields, each storing its value minus one: bit 31 is bypass, bits 30:18 the prescale P (1 to 8192), bits 17:12 the period field, bits 11:6 the high count H (1 to 64) and bits 5:0 the low/wrap count L (1 to 64, at least 2 for a usable clock).
- R2: In divided mode, the serial clock repeats every P*L system cycles, so its frequency is the system clock over P*L. Counting edges t = 1, 2, ... from the first edge that sees enable high, the clock after edge t is high exactly when floor(t/P) mod L is less than H.
- R3: Per period the clock stays high for H*P system cycles. If H is not less than L, the clock stays constantly high once enabled.
- R4: While enable is low, both counters are held at zero and the serial clock is low from the next edge on. Re-enabling restarts the waveform from its first phase.
- R5: With bypass set and enable high, the serial clock equals the system clock from the first edge on, and the prescale, high and low fields have no effect. In this mode both strobes are held high, because every system cycle contains one rising and one falling edge.
- R6: In divided mode the rise strobe is high for exactly the one cycle in which the clock first shows high, and the fall strobe is high for exactly the one cycle in which it first shows low again. This includes the drop caused by disabling. The two strobes are never high together.
- R7: The period field has no effect on the waveform. The wrap point comes only from the low field.
- R8: During and after reset, with enable low, the serial clock and both strobes are low.
- R9: The period counter advances only on prescaler terminal counts. With P = 8192 the first falling edge comes 8192 cycles after enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the divider; low holds it idle |
| cfgWord | input | 32 | Packed configuration word (see R1) |
| sclk | output | 1 | Serial clock |
| riseStb | output | 1 | One-cycle strobe on a rising serial clock edge |
| fallStb | output | 1 | One-cycle strobe on a falling serial clock edge |

## Verification
Every internal counter maps directly onto the registered serial clock. A prescaler off by one moves the first edge by one system cycle, and it shows at the port within P cycles of enabling. A wrong wrap point or high threshold changes the clock level within one serial period, and a stuck period counter freezes the level after the first tick. The strobes are compared against the level change on every cycle, so a strobe that is missing or duplicated shows up at the first edge it should mark.

// File: rtl/spi_sclk_div_pkg.sv
package spi_sclk_div_pkg;
  localparam int PRE_W = 13;
  localparam int PER_W = 6;
  localparam int CFG_W = 1 + PRE_W + 3 * PER_W;

  typedef struct packed {
    logic             bypass;
    logic [PRE_W-1:0] preM1;
    logic [PER_W-1:0] periodM1;
    logic [PER_W-1:0] highM1;
    logic [PER_W-1:0] lowM1;
  } divCfg_t;

  typedef struct packed {
    logic divRun;
    logic bypRun;
    logic phaseHigh;
  } divStb_t;
endpackage

// File: rtl/spi_sclk_div_ctrl.sv
module spi_sclk_div_ctrl
  import spi_sclk_div_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  divCfg_t cfg,
  output divStb_t stb
);
  logic [PRE_W-1:0] preCnt, preNext;
  logic [PER_W-1:0] perCnt, perNext;
  logic tick, run;
  logic unusedPeriod;

  // the period field is carried in the word but the wrap comes from the low field
  assign unusedPeriod = ^cfg.periodM1;

  always_comb begin
    run     = enable & ~cfg.bypass;
    tick    = (preCnt >= cfg.preM1);
    preNext = tick ? '0 : preCnt + 1'b1;
    if (tick) perNext = (perCnt >= cfg.lowM1) ? '0 : perCnt + 1'b1;
    else      perNext = perCnt;
    if (!run) begin
      preNext = '0;
      perNext = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      perCnt <= '0;
    end else begin
      preCnt <= preNext;
      perCnt <= perNext;
    end
  end

  assign stb.divRun    = run;
  assign stb.bypRun    = enable & cfg.bypass;
  assign stb.phaseHigh = (perNext <= cfg.highM1);

  // R4: idle holds both counters at zero
  a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (preCnt == '0 && perCnt == '0));

  // R9: the period counter moves only on a prescaler terminal count
  a_r9_step_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    (run && preCnt < cfg.preM1) |=> (perCnt == $past(perCnt)));
endmodule

// File: rtl/spi_sclk_div_dp.sv
module spi_sclk_div_dp
  import spi_sclk_div_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  divStb_t stb,
  output logic    sclk,
  output logic    riseStb,
  output logic    fallStb
);
  logic sclkReg, bypOn, newLvl;

  assign newLvl = stb.divRun & stb.phaseHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkReg <= 1'b0;
      bypOn   <= 1'b0;
      riseStb <= 1'b0;
      fallStb <= 1'b0;
    end else begin
      sclkReg <= newLvl;
      bypOn   <= stb.bypRun;
      riseStb <= stb.bypRun | (newLvl & ~sclkReg);
      fallStb <= stb.bypRun | (~newLvl & sclkReg);
    end
  end

  assign sclk = bypOn ? clk : sclkReg;

  // R6: strobes agree with the divided level and never coincide
  a_r6_rise_on_high: assert property (@(posedge clk) disable iff (!rstN)
    (!bypOn && riseStb) |-> sclkReg);
  a_r6_fall_on_low: assert property (@(posedge clk) disable iff (!rstN)
    (!bypOn && fallStb) |-> !sclkReg);
  a_r6_one_edge: assert property (@(posedge clk) disable iff (!rstN)
    !bypOn |-> !(riseStb && fallStb));
  // R4: idle drives the divided level low on the next edge
  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.divRun && !stb.bypRun) |=> (!sclkReg && !bypOn));
  // R5: bypass keeps both strobes high and the divided level parked
  a_r5_byp_strobes: assert property (@(posedge clk) disable iff (!rstN)
    bypOn |-> (riseStb && fallStb && !sclkReg));
endmodule

// File: rtl/spi_sclk_div.sv
module spi_sclk_div
  import spi_sclk_div_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [CFG_W-1:0] cfgWord,
  output logic             sclk,
  output logic             riseStb,
  output logic             fallStb
);
  divCfg_t cfg;
  divStb_t stb;

  assign cfg = divCfg_t'(cfgWord);

  spi_sclk_div_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .cfg(cfg), .stb(stb)
  );

  spi_sclk_div_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .sclk(sclk), .riseStb(riseStb), .fallStb(fallStb)
  );
endmodule

// File: tb/test_spi_sclk_div.sv
module test_spi_sclk_div;
  import spi_sclk_div_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [CFG_W-1:0] cfgWord = '0;
  logic sclk, riseStb, fallStb;

  always #2 clk = ~clk;

  spi_sclk_div i_spi_sclk_div (
    .clk(clk), .rstN(rstN), .enable(enable), .cfgWord(cfgWord),
    .sclk(sclk), .riseStb(riseStb), .fallStb(fallStb)
  );

  typedef struct {
    logic  s;
    logic  r;
    logic  f;
    string tag;
  } exp_t;

  exp_t q[$];
  int nChecks = 0;
  int nErr = 0;
  bit done = 1'b0;

  task automatic check(string tag, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s %s at %0t: actual=%0b expected=%0b", tag, what, $time, act, exp);
    end
  endtask

  // monitor: compare one expected item per edge, sampled after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "sclk", sclk, e.s);
        check(e.tag, "riseStb", riseStb, e.r);
        check(e.tag, "fallStb", fallStb, e.f);
      end
    end
  end

  function automatic logic [CFG_W-1:0] mkCfg(bit byp, int p, int per, int h, int l);
    return {byp, PRE_W'(p - 1), PER_W'(per - 1), PER_W'(h - 1), PER_W'(l - 1)};
  endfunction

  task automatic drainQ();
    wait (q.size() == 0);
  endtask

  // divided mode: expected level after edge t is ((t/P) mod L) < H
  task automatic runDiv(string tag, int p, int per, int h, int l, int n);
    logic prev;
    prev = 1'b0;
    @(negedge clk);
    cfgWord = mkCfg(1'b0, p, per, h, l);
    enable = 1'b1;
    for (int t = 1; t <= n; t++) begin
      logic lvl;
      lvl = (((t / p) % l) < h);
      q.push_back('{lvl, lvl & ~prev, ~lvl & prev, tag});
      prev = lvl;
    end
    drainQ();
    @(negedge clk);
    enable = 1'b0;
    q.push_back('{1'b0, 1'b0, prev, "R4"});
    q.push_back('{1'b0, 1'b0, 1'b0, "R4"});
    drainQ();
  endtask

  task automatic runByp(int n);
    @(negedge clk);
    cfgWord = mkCfg(1'b1, 5, 7, 3, 9);
    enable = 1'b1;
    for (int t = 1; t <= n; t++) q.push_back('{1'b1, 1'b1, 1'b1, "R5"});
    drainQ();
    @(negedge clk);
    #1;
    check("R5", "sclk low phase", sclk, 1'b0);
    @(negedge clk);
    enable = 1'b0;
    q.push_back('{1'b0, 1'b0, 1'b0, "R4"});
    q.push_back('{1'b0, 1'b0, 1'b0, "R4"});
    drainQ();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R8", "sclk in reset", sclk, 1'b0);
    check("R8", "riseStb in reset", riseStb, 1'b0);
    check("R8", "fallStb in reset", fallStb, 1'b0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check("R8", "sclk after reset", sclk, 1'b0);
    check("R8", "riseStb after reset", riseStb, 1'b0);

    runDiv("R2", 1, 2, 1, 2, 16);
    runDiv("R1", 3, 4, 1, 4, 40);
    runDiv("R6", 2, 5, 3, 5, 45);
    runDiv("R3", 1, 4, 4, 4, 20);
    runDiv("R3", 2, 4, 6, 4, 20);
    runDiv("R7", 2, 9, 2, 3, 30);
    runDiv("R7", 2, 3, 2, 3, 30);
    runByp(10);
    runDiv("R4", 3, 4, 2, 4, 25);
    runDiv("R9", 8192, 2, 1, 2, 8200);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog R2: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end
endmodule